// File: doc/BRIEF.md
# Recursive Quadratic Permutation Address Generator

This block produces the read or write addresses of a turbo-code interleaver whose permutation is the quadratic polynomial P(i) = (f1·i + f2·i²) mod N. It needs no multiplier, no divider and no address table. The address is updated with a second-order difference recursion. A running increment g is added to the current address, and a constant step (2·f2 mod N) is added to g. Every modular sum is an addition followed by at most one subtraction of N.

A `start` pulse captures the block length and both coefficients. The generator then walks the indices i = 0 … N−1. In free-running mode it produces one address per clock cycle. In stepped mode it moves by one index for each cycle in which `stepEn` is high. A valid flag marks the addresses, and a last flag marks index N−1. After the last index the generator stays idle until the next `start`. A decoder can therefore use the block for the natural-order sweep or the interleaved sweep of a half-iteration, and it can reload the parameters at run time for each new block length.

Top module: `qpp_addr_gen`

## Requirements
- R1: While reset is held, and after it is released with no `start`, `addrValid` and `addrLast` are 0 and `addrOut` is 0.
- R2: In the cycle after a `start` pulse, `addrValid` is 1 and `addrOut` is 0, which is the address for index 0.
- R3: Each address presented with `addrValid` high equals (f1·i + f2·i²) mod N exactly, where i is the index currently shown and f1 < N, f2 < N.
- R4: With `freeRun` = 1, the index advances on every cycle, so indices 0 … N−1 appear in N consecutive cycles.
- R5: With `freeRun` = 0, the index advances only on cycles with `stepEn` = 1. On other cycles `addrOut` and `addrValid` hold their values.
- R6: `addrLast` is 1 exactly while index N−1 is presented, and never while `addrValid` is 0.
- R7: An advance taken at index N−1 clears `addrValid`. After that, `stepEn` and `freeRun` have no effect until the next `start`.
- R8: A `start` pulse during a running sweep abandons it. The new parameters are used, and the sweep restarts at index 0.
- R9: Every presented address is below N. For a valid set of interleaver coefficients, the N addresses of a full sweep are all distinct.
- R10: `blockLen`, `coefF1` and `coefF2` are sampled only at `start`. Changing them during a sweep does not alter the addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads the parameters and restarts at index 0 |
| freeRun | input | 1 | 1: advance every cycle; 0: advance only on `stepEn` |
| stepEn | input | 1 | Advance request in stepped mode |
| blockLen | input | ADDR_W (13) | Block length N, from 40 to 6144 |
| coefF1 | input | ADDR_W (13) | Linear coefficient f1, below N |
| coefF2 | input | ADDR_W (13) | Quadratic coefficient f2, below N |
| addrOut | output | ADDR_W (13) | Interleaved address for the current index |
| addrValid | output | 1 | `addrOut` holds a valid address |
| addrLast | output | 1 | The current index is N−1 |

## Verification
Several properties are checked by the bound checker on every cycle: an address is always in range while valid, the last flag never appears without the valid flag, the output holds during a stall in stepped mode, the generator drops out after the last advance, it stays idle without a start, and index 0 follows a start. Exact address values, and whether a sweep is really a permutation, can only be shown by the bench's scenarios. The bench compares every address with a direct multiply-and-modulo model. It uses standard-style coefficient sets up to N = 6144, random parameter sets with random step gaps, restarts in mid-sweep, and parameter inputs that are scrambled during a sweep.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  // Strobes from the sequencing logic to the address datapath
  typedef struct packed {
    logic load;   // capture parameters, restart recursion
    logic step;   // move recursion to next index
  } qppStrobes_t;
endpackage

// File: rtl/qpp_mod_add.sv
module qpp_mod_add #(
  parameter int W = 13
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] result
);
  // Both operands are kept below modulus, so one subtraction suffices
  logic [W:0] rawSum;
  logic [W:0] reduced;

  always_comb begin
    rawSum  = {1'b0, opA} + {1'b0, opB};
    reduced = rawSum - {1'b0, modulus};
    result  = (rawSum >= {1'b0, modulus}) ? reduced[W-1:0] : rawSum[W-1:0];
  end
endmodule

// File: rtl/qpp_datapath.sv
module qpp_datapath
  import qpp_pkg::*;
#(
  parameter int W = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  qppStrobes_t strobes,
  input  logic [W-1:0] blockLen,
  input  logic [W-1:0] coefF1,
  input  logic [W-1:0] coefF2,
  output logic [W-1:0] lenQ,
  output logic [W-1:0] addrQ
);
  logic [W-1:0] incrQ;
  logic [W-1:0] deltaQ;
  logic [W-1:0] incrInit;
  logic [W-1:0] deltaInit;
  logic [W-1:0] addrNext;
  logic [W-1:0] incrNext;

  // Load-time reductions use the incoming block length
  qpp_mod_add #(.W(W)) uIncrInit (
    .opA(coefF1), .opB(coefF2), .modulus(blockLen), .result(incrInit)
  );
  qpp_mod_add #(.W(W)) uDeltaInit (
    .opA(coefF2), .opB(coefF2), .modulus(blockLen), .result(deltaInit)
  );

  // Running recursion uses the captured block length
  qpp_mod_add #(.W(W)) uAddrStep (
    .opA(addrQ), .opB(incrQ), .modulus(lenQ), .result(addrNext)
  );
  qpp_mod_add #(.W(W)) uIncrStep (
    .opA(incrQ), .opB(deltaQ), .modulus(lenQ), .result(incrNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ   <= '0;
      addrQ  <= '0;
      incrQ  <= '0;
      deltaQ <= '0;
    end else if (strobes.load) begin
      lenQ   <= blockLen;
      addrQ  <= '0;
      incrQ  <= incrInit;
      deltaQ <= deltaInit;
    end else if (strobes.step) begin
      addrQ  <= addrNext;
      incrQ  <= incrNext;
    end
  end
endmodule

// File: rtl/qpp_ctrl.sv
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int W = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        freeRun,
  input  logic        stepEn,
  input  logic [W-1:0] lenQ,
  output qppStrobes_t strobes,
  output logic        active,
  output logic        atLast
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] idxQ;
  logic         advance;

  assign advance = freeRun | stepEn;
  assign atLast  = active && (idxQ == lenQ - ONE);

  always_comb begin
    strobes.load = start;
    strobes.step = !start && active && advance;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      idxQ   <= '0;
    end else if (strobes.load) begin
      active <= 1'b1;
      idxQ   <= '0;
    end else if (strobes.step) begin
      if (atLast) active <= 1'b0;
      else        idxQ   <= idxQ + ONE;
    end
  end
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              freeRun,
  input  logic              stepEn,
  input  logic [ADDR_W-1:0] blockLen,
  input  logic [ADDR_W-1:0] coefF1,
  input  logic [ADDR_W-1:0] coefF2,
  output logic [ADDR_W-1:0] addrOut,
  output logic              addrValid,
  output logic              addrLast
);
  qppStrobes_t strobes;
  logic [ADDR_W-1:0] lenQ;

  qpp_ctrl #(.W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .freeRun(freeRun),
    .stepEn(stepEn), .lenQ(lenQ), .strobes(strobes),
    .active(addrValid), .atLast(addrLast)
  );

  qpp_datapath #(.W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .blockLen(blockLen),
    .coefF1(coefF1), .coefF2(coefF2), .lenQ(lenQ), .addrQ(addrOut)
  );
endmodule

// File: rtl/qpp_checker.sv
module qpp_checker #(
  parameter int W = 13
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         freeRun,
  input logic         stepEn,
  input logic [W-1:0] lenQ,
  input logic [W-1:0] addrOut,
  input logic         addrValid,
  input logic         addrLast
);
  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (addrValid && addrOut == '0)); // R2
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> (addrOut < lenQ)); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !freeRun && !stepEn && !start) |=> (addrValid && $stable(addrOut))); // R5
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    addrLast |-> addrValid); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (addrLast && (freeRun || stepEn) && !start) |=> !addrValid); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!addrValid && !start) |=> !addrValid); // R7
  AST_FREE_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !addrLast && freeRun && !start) |=> addrValid); // R4
endmodule

bind qpp_addr_gen qpp_checker #(.W(ADDR_W)) uChecker (
  .clk(clk), .rstN(rstN), .start(start), .freeRun(freeRun), .stepEn(stepEn),
  .lenQ(lenQ), .addrOut(addrOut), .addrValid(addrValid), .addrLast(addrLast)
);

// File: tb/tb_qpp_addr_gen.sv
module tb_qpp_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, freeRun = 1'b0, stepEn = 1'b0;
  logic [W-1:0] blockLen = '0, coefF1 = '0, coefF2 = '0;
  logic [W-1:0] addrOut;
  logic addrValid, addrLast;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit seen [0:8191];

  always #(CLK_PERIOD/2) clk = ~clk;

  qpp_addr_gen #(.ADDR_W(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .freeRun(freeRun), .stepEn(stepEn),
    .blockLen(blockLen), .coefF1(coefF1), .coefF2(coefF2),
    .addrOut(addrOut), .addrValid(addrValid), .addrLast(addrLast)
  );

  function automatic int refAddr(int idx, int n, int f1, int f2);
    longint v;
    v = (longint'(f1) * idx + longint'(f2) * idx * idx) % n;
    return int'(v);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Runs a sweep up to 'limit' indices; stepped mode uses random gaps.
  task automatic sweep(int n, int f1, int f2, bit free, int limit, bit permCheck);
    int idx = 0;
    int distinct = 0;
    bit en;
    for (int k = 0; k < 8192; k++) seen[k] = 0;
    @(negedge clk);
    blockLen = W'(n); coefF1 = W'(f1); coefF2 = W'(f2);
    freeRun = free; stepEn = 0; start = 1;
    @(negedge clk);
    start = 0;
    check(addrValid && addrOut == 0, "R2 start gives index 0", int'(addrOut), 0);
    while (idx < limit) begin
      check(addrValid == 1, "R4/R5 valid during sweep", int'(addrValid), 1);
      check(int'(addrOut) == refAddr(idx, n, f1, f2), "R3 address value",
            int'(addrOut), refAddr(idx, n, f1, f2));
      check(addrLast == (idx == n - 1), "R6 last flag", int'(addrLast), int'(idx == n - 1));
      check(int'(addrOut) < n, "R9 address range", int'(addrOut), n - 1);
      if (!seen[addrOut]) distinct++;
      seen[addrOut] = 1;
      en = free ? 1'b1 : ($urandom % 3 != 0);
      stepEn = en;
      // R10: parameter inputs scrambled mid-sweep must not matter
      blockLen = W'($urandom); coefF1 = W'($urandom); coefF2 = W'($urandom);
      @(negedge clk);
      if (en) idx++;
    end
    if (limit == n) begin
      check(addrValid == 0, "R7 valid drops after last", int'(addrValid), 0);
      stepEn = 1; freeRun = 1;
      repeat (3) @(negedge clk);
      check(addrValid == 0 && addrLast == 0, "R7 idle ignores advance", int'(addrValid), 0);
      stepEn = 0; freeRun = free;
      if (permCheck) check(distinct == n, "R9 permutation distinct count", distinct, n);
    end
  endtask

  task automatic freeCount(int n, int f1, int f2);
    int cycles = 0;
    @(negedge clk);
    blockLen = W'(n); coefF1 = W'(f1); coefF2 = W'(f2);
    freeRun = 1; stepEn = 0; start = 1;
    @(negedge clk);
    start = 0;
    while (addrValid && cycles < n + 5) begin
      cycles++;
      @(negedge clk);
    end
    check(cycles == n, "R4 one address per cycle", cycles, n);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(addrValid == 0 && addrLast == 0 && addrOut == 0, "R1 reset state", int'(addrValid), 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    stepEn = 1; freeRun = 1;
    @(negedge clk);
    check(addrValid == 0 && addrOut == 0, "R1 idle after reset", int'(addrValid), 0);
    stepEn = 0; freeRun = 0;

    sweep(40, 3, 10, 1, 40, 1);
    sweep(40, 3, 10, 0, 40, 1);
    sweep(48, 7, 12, 1, 48, 1);
    sweep(56, 19, 42, 0, 56, 1);
    sweep(104, 7, 26, 1, 104, 1);
    sweep(512, 31, 64, 0, 512, 1);
    sweep(1024, 31, 64, 1, 1024, 1);
    sweep(6144, 263, 480, 1, 6144, 1);
    freeCount(64, 7, 16);

    // R8: restarts mid-sweep with random parameters
    for (int t = 0; t < 6; t++) begin
      int n = 40 + int'($urandom % 6105);
      int f1 = int'($urandom % n);
      int f2 = int'($urandom % n);
      sweep(n, f1, f2, t[0], 150, 0);
    end
    begin
      int n = 40 + int'($urandom % 200);
      sweep(n, int'($urandom % n), int'($urandom % n), 0, n, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule